// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps the program order of a speculative out-of-order core. Every instruction that issues claims one slot at the tail of a circular buffer, and the slot index it receives becomes the tag that its result carries on the common result bus. When the result arrives, the value is parked in that slot and the slot is marked done. Nothing reaches architectural state at that point. Retirement happens only at the head of the buffer, in the order in which the slots were claimed.

When a register operation retires, it writes its value into the register file. When a store retires, it hands its address and data to memory, and it does so only at retirement. A branch that was predicted correctly retires without any side effect. A branch found to be mispredicted when it reaches the head raises a flush together with the corrected fetch address. Every slot is then discarded, and the buffer is empty again on the next clock edge.

The allocate port is a valid/ready stream. An instruction is taken only on a cycle where both `alloc_valid` and `alloc_ready` are high. `alloc_ready` drops while all slots are in use and during a flush cycle. The store output is also a valid/ready stream. A store offered at the head stays on `st_valid` with stable address and data until memory returns `st_ready`, and all retirement waits behind it. The result bus and the register write port always accept, so they carry no ready signal.

Top module: `rob_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the buffer is empty: `alloc_ready` is 1, and `rf_we`, `st_valid` and `flush` are 0.
- R2: An accepted allocation returns on `alloc_tag` the slot it was given. Slots are handed out in ascending order modulo 16, starting from 0 after reset and after each flush. The kind code is 0 for a register operation, 1 for a store and 2 for a branch; code 3 is reserved and never presented.
- R3: With 16 slots occupied, `alloc_ready` is 0 and an offered instruction is not taken. It rises again once a slot retires.
- R4: A broadcast whose tag names an occupied slot with no result yet stores the value and marks the slot done, and the slot may retire from the next cycle. A broadcast to an unoccupied slot has no effect: a later instruction given that slot does not retire until its own result arrives.
- R5: Retirement is strictly in allocation order, at most one per cycle, and only from the head once its result is present. For a register operation (kind 0), `rf_we` is 1 for exactly that cycle, with `rf_idx` set to the destination and `rf_data` to the result.
- R6: A store (kind 1) at the head with its data present drives `st_valid` with `st_addr` set to the destination and `st_data` to the result. Both stay stable until `st_ready` is 1, and the store retires on that handshake.
- R7: A branch (kind 2) at the head whose result arrived with the mispredict bit clear retires in one cycle with `rf_we`, `st_valid` and `flush` all 0.
- R8: A branch (kind 2) at the head whose result arrived with the mispredict bit set drives `flush` for one cycle with `redirect_pc` set to the target that came with its result. `alloc_ready` is 0 in that cycle, and after the next edge the buffer is empty with the next allocation receiving slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | An issued instruction is offered |
| alloc_ready | output | 1 | A slot is free and no flush is under way |
| alloc_kind | input | 2 | 0 register op, 1 store, 2 branch |
| alloc_dest | input | DEST_W (16) | Destination register number or store address |
| alloc_tag | output | TAG_W (4) | Slot index handed to the offered instruction |
| cdb_valid | input | 1 | A result is broadcast this cycle |
| cdb_tag | input | TAG_W (4) | Slot the result belongs to |
| cdb_value | input | DATA_W (32) | Result value or store data |
| cdb_mispredict | input | 1 | Branch outcome differs from the prediction |
| cdb_target | input | PC_W (32) | Correct fetch address for a branch |
| rf_we | output | 1 | Register file write strobe |
| rf_idx | output | DEST_W (16) | Register written |
| rf_data | output | DATA_W (32) | Value written |
| st_valid | output | 1 | A store is released to memory |
| st_ready | input | 1 | Memory accepts the store |
| st_addr | output | DEST_W (16) | Store address |
| st_data | output | DATA_W (32) | Store data |
| flush | output | 1 | Mispredicted branch retired; discard younger work |
| redirect_pc | output | PC_W (32) | Fetch restart address, valid with flush |

## Verification
The assertions check on every cycle that no instruction is taken into a full buffer or during a flush, that a flush leaves the occupancy at zero, that at most one of register write, store and flush happens in a cycle, that a stalled store holds its address and data, and that the occupancy moves by exactly the number of allocations minus retirements. Only the bench scenarios can show that retirement follows allocation order under every order of result arrival, that slot numbering wraps and restarts after a flush, that values, addresses and redirect targets reach the right outputs, and that a broadcast to an empty slot is forgotten. The bench shows these by sweeping result latency over the whole depth, varying store back-pressure, and comparing the outputs against an arithmetic program-order model.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_RSVD   = 2'd3
  } rob_kind_e;

  // per-slot control bits; wide payload lives in separate arrays
  typedef struct packed {
    logic      busy;
    logic      done;
    rob_kind_e kind;
    logic      mispred;
  } rob_ctl_t;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [TAG_W:0]   count,
  output logic             full
);
  localparam int CNT_W = TAG_W + 1;

  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (alloc_fire)  tail_q <= bump(tail_q);
      if (retire_fire) head_q <= bump(head_q);
      count_q <= count_q + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign count = count_q;
  assign full  = (count_q == CNT_W'(DEPTH));
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  parameter int DEST_W = 16,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_fire,
  input  logic [TAG_W-1:0]  tail,
  input  rob_kind_e         alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              cdb_mispredict,
  input  logic [PC_W-1:0]   cdb_target,
  input  logic              retire_fire,
  input  logic [TAG_W-1:0]  head,
  output rob_ctl_t          head_ctl,
  output logic [DEST_W-1:0] head_dest,
  output logic [DATA_W-1:0] head_value,
  output logic [PC_W-1:0]   head_target
);
  rob_ctl_t          ctl_q    [DEPTH];
  logic [DEST_W-1:0] dest_q   [DEPTH];
  logic [DATA_W-1:0] value_q  [DEPTH];
  logic [PC_W-1:0]   target_q [DEPTH];
  logic [DEPTH-1:0]  hit;

  // a broadcast lands only in an occupied slot still waiting for its result
  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign hit[g] = cdb_valid && (cdb_tag == TAG_W'(g)) &&
                    ctl_q[g].busy && !ctl_q[g].done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctl_q[i] <= '0;
    end else if (flush) begin
      for (int i = 0; i < DEPTH; i++) begin
        ctl_q[i].busy <= 1'b0;
        ctl_q[i].done <= 1'b0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (retire_fire && head == TAG_W'(i)) begin
          ctl_q[i].busy <= 1'b0;
          ctl_q[i].done <= 1'b0;
        end
        if (alloc_fire && tail == TAG_W'(i)) begin
          ctl_q[i] <= '{busy: 1'b1, done: 1'b0, kind: alloc_kind, mispred: 1'b0};
        end
        if (hit[i]) begin
          ctl_q[i].done    <= 1'b1;
          ctl_q[i].mispred <= cdb_mispredict;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_fire && tail == TAG_W'(i)) dest_q[i] <= alloc_dest;
      if (hit[i]) begin
        value_q[i]  <= cdb_value;
        target_q[i] <= cdb_target;
      end
    end
  end

  assign head_ctl    = ctl_q[head];
  assign head_dest   = dest_q[head];
  assign head_value  = value_q[head];
  assign head_target = target_q[head];
endmodule

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl
  import rob_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEST_W = 16,
  parameter int PC_W   = 32
) (
  input  rob_ctl_t          head_ctl,
  input  logic [DEST_W-1:0] head_dest,
  input  logic [DATA_W-1:0] head_value,
  input  logic [PC_W-1:0]   head_target,
  input  logic              st_ready,
  output logic              rf_we,
  output logic [DEST_W-1:0] rf_idx,
  output logic [DATA_W-1:0] rf_data,
  output logic              st_valid,
  output logic [DEST_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  output logic              flush,
  output logic [PC_W-1:0]   redirect_pc,
  output logic              retire_fire
);
  logic live, is_br_ok;

  always_comb begin
    live        = head_ctl.busy && head_ctl.done;
    rf_we       = live && (head_ctl.kind == KIND_REG);
    st_valid    = live && (head_ctl.kind == KIND_STORE);
    is_br_ok    = live && (head_ctl.kind == KIND_BRANCH) && !head_ctl.mispred;
    flush       = live && (head_ctl.kind == KIND_BRANCH) && head_ctl.mispred;
    retire_fire = rf_we || (st_valid && st_ready) || is_br_ok;
    rf_idx      = head_dest;
    rf_data     = head_value;
    st_addr     = head_dest;
    st_data     = head_value;
    redirect_pc = head_target;
  end
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter  int DEPTH  = 16,
  parameter  int DATA_W = 32,
  parameter  int DEST_W = 16,
  parameter  int PC_W   = 32,
  localparam int TAG_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [1:0]        alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              cdb_mispredict,
  input  logic [PC_W-1:0]   cdb_target,
  output logic              rf_we,
  output logic [DEST_W-1:0] rf_idx,
  output logic [DATA_W-1:0] rf_data,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [DEST_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  output logic              flush,
  output logic [PC_W-1:0]   redirect_pc
);
  logic [TAG_W-1:0]  head, tail;
  logic [TAG_W:0]    count;
  logic              full, alloc_fire, retire_fire;
  rob_ctl_t          head_ctl;
  logic [DEST_W-1:0] head_dest;
  logic [DATA_W-1:0] head_value;
  logic [PC_W-1:0]   head_target;

  assign alloc_ready = !full && !flush;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;

  rob_ptr_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ptrs (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_fire),
    .retire_fire (retire_fire),
    .flush       (flush),
    .head        (head),
    .tail        (tail),
    .count       (count),
    .full        (full)
  );

  rob_entry_array #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .DEST_W(DEST_W), .PC_W(PC_W)
  ) u_slots (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .alloc_fire     (alloc_fire),
    .tail           (tail),
    .alloc_kind     (rob_kind_e'(alloc_kind)),
    .alloc_dest     (alloc_dest),
    .cdb_valid      (cdb_valid),
    .cdb_tag        (cdb_tag),
    .cdb_value      (cdb_value),
    .cdb_mispredict (cdb_mispredict),
    .cdb_target     (cdb_target),
    .retire_fire    (retire_fire),
    .head           (head),
    .head_ctl       (head_ctl),
    .head_dest      (head_dest),
    .head_value     (head_value),
    .head_target    (head_target)
  );

  rob_retire_ctrl #(.DATA_W(DATA_W), .DEST_W(DEST_W), .PC_W(PC_W)) u_retire (
    .head_ctl    (head_ctl),
    .head_dest   (head_dest),
    .head_value  (head_value),
    .head_target (head_target),
    .st_ready    (st_ready),
    .rf_we       (rf_we),
    .rf_idx      (rf_idx),
    .rf_data     (rf_data),
    .st_valid    (st_valid),
    .st_addr     (st_addr),
    .st_data     (st_data),
    .flush       (flush),
    .redirect_pc (redirect_pc),
    .retire_fire (retire_fire)
  );
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  parameter int DEST_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              alloc_ready,
  input logic              rf_we,
  input logic              st_valid,
  input logic              st_ready,
  input logic [DEST_W-1:0] st_addr,
  input logic [DATA_W-1:0] st_data,
  input logic              flush,
  input logic [TAG_W:0]    count,
  input logic              retire_fire
);
  // R3
  full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == (TAG_W+1)'(DEPTH)) |-> !alloc_ready);

  // R8
  flush_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !alloc_ready);

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  // R5
  one_retire_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, st_valid, flush}));

  // R6
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_addr) && $stable(st_data)));

  // R5
  occupancy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (count == $past(count) + (TAG_W+1)'($past(alloc_valid && alloc_ready))
                                      - (TAG_W+1)'($past(retire_fire))));
endmodule

bind rob_top rob_chk #(
  .DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .DEST_W(DEST_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .rf_we       (rf_we),
  .st_valid    (st_valid),
  .st_ready    (st_ready),
  .st_addr     (st_addr),
  .st_data     (st_data),
  .flush       (flush),
  .count       (count),
  .retire_fire (retire_fire)
);

// File: tb/rob_top_tb.sv
module rob_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 32;
  localparam int DEST_W = 16;
  localparam int PC_W   = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alloc_valid, alloc_ready;
  logic [1:0]        alloc_kind;
  logic [DEST_W-1:0] alloc_dest;
  logic [TAG_W-1:0]  alloc_tag;
  logic              cdb_valid, cdb_mispredict;
  logic [TAG_W-1:0]  cdb_tag;
  logic [DATA_W-1:0] cdb_value;
  logic [PC_W-1:0]   cdb_target;
  logic              rf_we, st_valid, st_ready, flush;
  logic [DEST_W-1:0] rf_idx, st_addr;
  logic [DATA_W-1:0] rf_data, st_data;
  logic [PC_W-1:0]   redirect_pc;

  rob_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .alloc_tag(alloc_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .cdb_mispredict(cdb_mispredict), .cdb_target(cdb_target),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .flush(flush), .redirect_pc(redirect_pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // program-order model
  int  m_kind [DEPTH];
  int  m_dest [DEPTH];
  logic [DATA_W-1:0] m_value [DEPTH];
  logic [PC_W-1:0]   m_tgt   [DEPTH];
  bit  m_mis [DEPTH];
  bit  m_res [DEPTH];
  int  m_head = 0, m_tail = 0, m_cnt = 0;
  int  chk_cnt = 0, fail_cnt = 0, n_flush = 0;
  bit  chk_en = 0, finished = 0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    chk_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
      $finish;
    end
  endtask

  function automatic bit occupied(int t);
    return ((t - m_head + DEPTH) % DEPTH) < m_cnt;
  endfunction

  function automatic int oldest_unres();
    for (int j = 0; j < m_cnt; j++) if (!m_res[(m_head + j) % DEPTH]) return (m_head + j) % DEPTH;
    return -1;
  endfunction

  function automatic int youngest_unres();
    for (int j = m_cnt - 1; j >= 0; j--) if (!m_res[(m_head + j) % DEPTH]) return (m_head + j) % DEPTH;
    return -1;
  endfunction

  function automatic int unres_count();
    int n = 0;
    for (int j = 0; j < m_cnt; j++) if (!m_res[(m_head + j) % DEPTH]) n++;
    return n;
  endfunction

  // compare outputs with the model away from the clock edge, then advance the model
  always @(negedge clk) begin
    if (chk_en) begin
      bit live, exp_rf, exp_st, exp_fl, exp_ar, ret;
      int k;
      live   = (m_cnt > 0) && m_res[m_head];
      k      = m_kind[m_head];
      exp_rf = live && k == 0;
      exp_st = live && k == 1;
      exp_fl = live && k == 2 && m_mis[m_head];
      check(rf_we == exp_rf, "R5", "rf_we", 64'(rf_we), 64'(exp_rf));
      check(st_valid == exp_st, "R6", "st_valid", 64'(st_valid), 64'(exp_st));
      check(flush == exp_fl, "R8", "flush", 64'(flush), 64'(exp_fl));
      if (live && k == 2 && !m_mis[m_head])
        check(!rf_we && !st_valid && !flush, "R7", "quiet branch retire",
              64'({rf_we, st_valid, flush}), 64'(0));
      if (exp_rf && rf_we) begin
        check(rf_idx == DEST_W'(m_dest[m_head]), "R5", "rf_idx", 64'(rf_idx), 64'(m_dest[m_head]));
        check(rf_data == m_value[m_head], "R5", "rf_data", 64'(rf_data), 64'(m_value[m_head]));
      end
      if (exp_st && st_valid) begin
        check(st_addr == DEST_W'(m_dest[m_head]), "R6", "st_addr", 64'(st_addr), 64'(m_dest[m_head]));
        check(st_data == m_value[m_head], "R6", "st_data", 64'(st_data), 64'(m_value[m_head]));
      end
      if (exp_fl && flush) begin
        check(redirect_pc == m_tgt[m_head], "R8", "redirect_pc", 64'(redirect_pc), 64'(m_tgt[m_head]));
        check(alloc_ready == 1'b0, "R8", "alloc_ready in flush", 64'(alloc_ready), 64'(0));
      end
      exp_ar = (m_cnt < DEPTH) && !exp_fl;
      if (alloc_valid) begin
        check(alloc_ready == exp_ar, "R3", "alloc_ready", 64'(alloc_ready), 64'(exp_ar));
        if (exp_ar) check(alloc_tag == TAG_W'(m_tail), "R2", "alloc_tag", 64'(alloc_tag), 64'(m_tail));
      end
      if (exp_fl) begin
        m_head = 0; m_tail = 0; m_cnt = 0; n_flush++;
        for (int i = 0; i < DEPTH; i++) m_res[i] = 0;
      end else begin
        if (cdb_valid && occupied(int'(cdb_tag)) && !m_res[cdb_tag]) begin
          m_res[cdb_tag]   = 1;
          m_value[cdb_tag] = cdb_value;
          m_mis[cdb_tag]   = cdb_mispredict;
          m_tgt[cdb_tag]   = cdb_target;
        end
        ret = live && (k == 0 || k == 2 || (k == 1 && st_ready));
        if (ret) begin
          m_res[m_head] = 0; m_head = (m_head + 1) % DEPTH; m_cnt--;
        end
        if (alloc_valid && exp_ar) begin
          m_kind[m_tail] = int'(alloc_kind);
          m_dest[m_tail] = int'(alloc_dest);
          m_res[m_tail]  = 0;
          m_tail = (m_tail + 1) % DEPTH; m_cnt++;
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic drive_alloc(int kind, int seq);
    alloc_valid = 1'b1;
    alloc_kind  = 2'(kind);
    alloc_dest  = DEST_W'(seq * 5 + 3);
  endtask

  task automatic drive_cdb(int tag, int seq, bit mis);
    cdb_valid      = 1'b1;
    cdb_tag        = TAG_W'(tag);
    cdb_value      = DATA_W'(seq) * 32'h9E37 + 32'h11;
    cdb_mispredict = mis;
    cdb_target     = 32'h4000 + PC_W'(seq) * 4;
  endtask

  // resolve the oldest pending slot each cycle with no allocation
  task automatic drain(int n, int bp);
    for (int c = 0; c < n; c++) begin
      int t;
      alloc_valid = 1'b0;
      t = oldest_unres();
      if (t >= 0) drive_cdb(t, 900 + c, 1'b0); else cdb_valid = 1'b0;
      st_ready = ((c % bp) == 0);
      tick();
    end
    cdb_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 64'(0), 64'(1));
    finish_run();
  end

  initial begin
    int seq;
    rst_n = 1'b0; alloc_valid = 1'b0; alloc_kind = '0; alloc_dest = '0;
    cdb_valid = 1'b0; cdb_tag = '0; cdb_value = '0; cdb_mispredict = 1'b0; cdb_target = '0;
    st_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(alloc_ready == 1'b1, "R1", "alloc_ready in reset", 64'(alloc_ready), 64'(1));
    check(!rf_we && !st_valid && !flush, "R1", "outputs in reset",
          64'({rf_we, st_valid, flush}), 64'(0));
    @(posedge clk); #1;
    rst_n = 1'b1; chk_en = 1'b1;
    @(negedge clk);
    check(alloc_ready == 1'b1 && !rf_we && !st_valid && !flush, "R1", "after reset",
          64'({alloc_ready, rf_we, st_valid, flush}), 64'(8));
    @(posedge clk); #1;

    // fill beyond capacity (R2, R3), resolve in a scrambled order (R4, R5)
    for (int i = 0; i <= DEPTH; i++) begin drive_alloc(0, i); tick(); end
    alloc_valid = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin drive_cdb((k * 7 + 3) % DEPTH, 100 + k, 1'b0); tick(); end
    cdb_valid = 1'b0;
    repeat (20) tick();

    // mixed kinds resolved youngest first under store back-pressure (R6, R7)
    for (int bp = 1; bp <= 3; bp++) begin
      for (int i = 0; i < 12; i++) begin drive_alloc(i % 3, 200 + i); tick(); end
      alloc_valid = 1'b0;
      for (int c = 0; c < 12; c++) begin
        int t;
        t = youngest_unres();
        if (t >= 0) drive_cdb(t, 300 + c, 1'b0); else cdb_valid = 1'b0;
        st_ready = ((c % bp) == 0);
        tick();
      end
      drain(30, bp);
    end

    // mispredicted branch in the middle, younger work already done (R8)
    begin
      int br_tag;
      st_ready = 1'b1;
      for (int i = 0; i < 10; i++) begin drive_alloc((i == 4) ? 2 : (i % 2), 400 + i); tick(); end
      alloc_valid = 1'b0;
      br_tag = (m_head + 4) % DEPTH;
      for (int c = 0; c < 10; c++) begin
        int t;
        t = youngest_unres();
        if (t >= 0) drive_cdb(t, 500 + c, t == br_tag); else cdb_valid = 1'b0;
        tick();
      end
      drain(10, 1);
      check(n_flush == 1, "R8", "flush count", 64'(n_flush), 64'(1));
      drive_alloc(0, 600); tick();  // R2: slot 0 after the flush, checked by the monitor
      alloc_valid = 1'b0;
      drain(5, 1);
    end

    // broadcast into an empty slot is forgotten (R4)
    drive_cdb(m_tail, 700, 1'b0); tick();
    cdb_valid = 1'b0;
    drive_alloc(0, 701); tick();
    alloc_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(rf_we == 1'b0, "R4", "stale broadcast retired", 64'(rf_we), 64'(0));
    end
    @(posedge clk); #1;
    drain(5, 1);

    // streaming sweep over result latency 0..15 with wrap-around and flushes
    seq = 1000;
    for (int lag = 0; lag < DEPTH; lag++) begin
      for (int c = 0; c < 48; c++) begin
        drive_alloc(seq % 3, seq);
        if (unres_count() > lag) begin
          int t;
          t = oldest_unres();
          drive_cdb(t, seq, (m_kind[t] == 2) && (((t + lag) % 4) == 0));
        end else cdb_valid = 1'b0;
        st_ready = ((c + lag) % 3) != 0;
        seq++;
        tick();
      end
      drain(40, 1);
    end
    check(n_flush > 1, "R8", "sweep produced flushes", 64'(n_flush), 64'(2));

    chk_en = 1'b0;
    finish_run();
  end
endmodule